// File: doc/BRIEF.md
# UART Interrupt Enable and Source Reporting

This block turns the status of one UART channel into a single host interrupt line and a three-bit source code. Four enable bits, written by the host in one store, gate four sources: receive data available, transmitter ready, receive line status and modem status. The receive and transmit FIFO levels, their programmed trigger levels, the per-character error flags, the overrun strobe and the modem change flags come from the neighbouring datapath. Here they are plain inputs.

Line status and modem status are sticky. Each stays pending until the host reads the matching status register. Transmit ready is raised on an edge and cleared by the host, while receive data follows the FIFO level directly. When several sources are active, the code names the most urgent one. With all enables cleared the host runs the channel by polling alone.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enables read 0000, `irq` is 0 and `irq_src` is 3'b001 (nothing pending).
- R2: With `fifo_en`=1 and enable bit 0 set, the receive source is active while `rx_count` >= `rx_trig` and inactive once it drops below.
- R3: With `fifo_en`=0 and enable bit 0 set, the receive source is active while `rx_hold_full` is 1.
- R4: The transmit source becomes pending when its condition rises: `tx_count` < `tx_trig` in FIFO mode, or `tx_hold_empty` when FIFO mode is off. Enable bit 1 gates it.
- R5: Writing enable bit 1 from 0 to 1 while the transmit condition already holds makes the transmit source pending at once.
- R6: A pending transmit source clears on `tx_write`, or on `iir_read` while `irq_src` reports transmit (3'b010).
- R7: `overrun_pulse` makes the line status source pending on the next edge.
- R8: With `err_immediate`=0, parity/framing/break flags (`rx_*_err` bits 0..2) raise line status only with `rx_pop`, and are ignored with `rx_push`.
- R9: With `err_immediate`=1, those flags raise line status with `rx_push` and are ignored with `rx_pop`.
- R10: `lsr_read` clears a pending line status. A new line status event in the same cycle wins, and the status stays pending.
- R11: Any `msr_change` bit makes the modem source pending, and `msr_read` clears it. Enable bit 3 gates it.
- R12: With enables 0000, `irq` stays 0 whatever the sources do.
- R13: `irq_src` names the highest pending enabled source: line status 3'b110, then receive 3'b100, then transmit 3'b010, then modem 3'b000. `irq` is 1 exactly when a source is named. All outputs update on the edge after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enables: 0 rx, 1 tx, 2 line status, 3 modem |
| fifo_en | input | 1 | FIFO mode on |
| rx_count | input | CW | Receive FIFO fill |
| rx_trig | input | CW | Receive trigger level |
| tx_count | input | CW | Transmit FIFO fill |
| tx_trig | input | CW | Transmit trigger level |
| rx_hold_full | input | 1 | Receive holding register full (FIFO off) |
| tx_hold_empty | input | 1 | Transmit holding register empty (FIFO off) |
| rx_push | input | 1 | Character arrives |
| rx_push_err | input | 3 | Errors of arriving character: parity, framing, break |
| rx_pop | input | 1 | Character read by host |
| rx_pop_err | input | 3 | Errors of character read |
| overrun_pulse | input | 1 | Overrun strobe |
| err_immediate | input | 1 | Error timing: 1 on arrival, 0 on read |
| msr_change | input | 4 | Modem line change flags |
| msr_read | input | 1 | Host reads modem status |
| lsr_read | input | 1 | Host reads line status |
| iir_read | input | 1 | Host reads source code |
| tx_write | input | 1 | Host writes transmit data |
| irq | output | 1 | Interrupt to host |
| irq_src | output | 3 | Source code |
| ier_out | output | 4 | Current enables |

## Verification
A line status clear and a new line status event can land in the same cycle. The bench drives `lsr_read` and `overrun_pulse` on one edge and expects line status still reported afterwards. A second such collision is between an enable write and the transmit condition. The bench clears the transmit pending flag while the transmitter stays empty, then writes the enable and expects the transmit code on the next edge. That value could only come from the enable edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    typedef enum logic [2:0] {
        SRC_MS   = 3'b000,
        SRC_NONE = 3'b001,
        SRC_TX   = 3'b010,
        SRC_RX   = 3'b100,
        SRC_LS   = 3'b110
    } irq_src_e;

    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;
    localparam int EN_W  = 4;

    typedef struct packed {
        logic [EN_W-1:0] ier;
        logic            ls_pend;
        logic            tx_pend;
        logic            ms_pend;
        logic            tx_cond;
        logic            irq;
        irq_src_e        src;
    } irq_state_t;
endpackage

// File: rtl/uart_irq_cond.sv
module uart_irq_cond #(
    parameter int CW = 7
) (
    input  logic          fifo_en,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trig,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] tx_trig,
    input  logic          rx_hold_full,
    input  logic          tx_hold_empty,
    output logic          rx_cond,
    output logic          tx_cond
);
    always_comb begin
        if (fifo_en) begin
            rx_cond = (rx_count >= rx_trig);
            tx_cond = (tx_count < tx_trig);
        end else begin
            rx_cond = rx_hold_full;
            tx_cond = tx_hold_empty;
        end
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic     ls_act,
    input  logic     rx_act,
    input  logic     tx_act,
    input  logic     ms_act,
    output logic     any_act,
    output irq_src_e src
);
    always_comb begin
        if (ls_act)      src = SRC_LS;
        else if (rx_act) src = SRC_RX;
        else if (tx_act) src = SRC_TX;
        else if (ms_act) src = SRC_MS;
        else             src = SRC_NONE;
        any_act = ls_act | rx_act | tx_act | ms_act;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ier_wr,
    input  logic [EN_W-1:0] ier_wdata,
    input  logic            fifo_en,
    input  logic [CW-1:0]   rx_count,
    input  logic [CW-1:0]   rx_trig,
    input  logic [CW-1:0]   tx_count,
    input  logic [CW-1:0]   tx_trig,
    input  logic            rx_hold_full,
    input  logic            tx_hold_empty,
    input  logic            rx_push,
    input  logic [2:0]      rx_push_err,
    input  logic            rx_pop,
    input  logic [2:0]      rx_pop_err,
    input  logic            overrun_pulse,
    input  logic            err_immediate,
    input  logic [3:0]      msr_change,
    input  logic            msr_read,
    input  logic            lsr_read,
    input  logic            iir_read,
    input  logic            tx_write,
    output logic            irq,
    output logic [2:0]      irq_src,
    output logic [EN_W-1:0] ier_out
);
    irq_state_t      st_q, st_d;
    logic            rx_cond, tx_cond;
    logic [EN_W-1:0] ier_nx;
    logic            ls_nx, tx_nx, ms_nx;
    logic            ls_set, tx_set, tx_clr;
    logic            p_any;
    irq_src_e        p_src;

    uart_irq_cond #(.CW(CW)) u_cond (
        .fifo_en      (fifo_en),
        .rx_count     (rx_count),
        .rx_trig      (rx_trig),
        .tx_count     (tx_count),
        .tx_trig      (tx_trig),
        .rx_hold_full (rx_hold_full),
        .tx_hold_empty(tx_hold_empty),
        .rx_cond      (rx_cond),
        .tx_cond      (tx_cond)
    );

    // next values of enables and sticky pending flags; a set beats a clear
    always_comb begin
        ier_nx = ier_wr ? ier_wdata : st_q.ier;

        ls_set = overrun_pulse
               | (rx_push & (|rx_push_err) &  err_immediate)
               | (rx_pop  & (|rx_pop_err)  & ~err_immediate);
        ls_nx  = ls_set | (st_q.ls_pend & ~lsr_read);

        tx_set = (tx_cond & ~st_q.tx_cond)
               | (ier_wr & ier_wdata[EN_TX] & ~st_q.ier[EN_TX] & tx_cond);
        tx_clr = tx_write | (iir_read & (st_q.src == SRC_TX));
        tx_nx  = tx_set | (st_q.tx_pend & ~tx_clr);

        ms_nx  = (|msr_change) | (st_q.ms_pend & ~msr_read);
    end

    uart_irq_prio u_prio (
        .ls_act (ls_nx   & ier_nx[EN_LS]),
        .rx_act (rx_cond & ier_nx[EN_RX]),
        .tx_act (tx_nx   & ier_nx[EN_TX]),
        .ms_act (ms_nx   & ier_nx[EN_MS]),
        .any_act(p_any),
        .src    (p_src)
    );

    always_comb begin
        st_d         = st_q;
        st_d.ier     = ier_nx;
        st_d.ls_pend = ls_nx;
        st_d.tx_pend = tx_nx;
        st_d.ms_pend = ms_nx;
        st_d.tx_cond = tx_cond;
        st_d.irq     = p_any;
        st_d.src     = p_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.src <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign irq_src = st_q.src;
    assign ier_out = st_q.ier;

    // R7: overrun with line status enabled is reported on the next edge
    a_r7_overrun_now: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_pulse && st_q.ier[EN_LS] && !ier_wr |=> irq && irq_src == SRC_LS);

    // R5: enabling transmit while the transmitter is empty interrupts at once
    a_r5_tx_enable_fires: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr && ier_wdata[EN_TX] && !st_q.ier[EN_TX] && tx_cond |=> irq);

    // R12: enables all zero keep the line quiet
    a_r12_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ier == '0 && !ier_wr |=> !irq);

    // R11: modem source never reported while its enable is off
    a_r11_ms_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ier[EN_MS] && !ier_wr |=> irq_src != SRC_MS);

    // R10: a status read with no new error removes line status
    a_r10_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_read && !overrun_pulse && !(rx_push && |rx_push_err)
        && !(rx_pop && |rx_pop_err) |=> irq_src != SRC_LS);

    // R13: interrupt line agrees with the reported code
    a_r13_irq_matches_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_src != SRC_NONE));
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
    localparam int CW = 7;

    logic clk = 0, rst_n = 0;
    logic ier_wr = 0;
    logic [3:0] ier_wdata = 0;
    logic fifo_en = 1;
    logic [CW-1:0] rx_count = 0, rx_trig = 8, tx_count = 10, tx_trig = 4;
    logic rx_hold_full = 0, tx_hold_empty = 0;
    logic rx_push = 0, rx_pop = 0;
    logic [2:0] rx_push_err = 0, rx_pop_err = 0;
    logic overrun_pulse = 0, err_immediate = 0;
    logic [3:0] msr_change = 0;
    logic msr_read = 0, lsr_read = 0, iir_read = 0, tx_write = 0;
    logic irq;
    logic [2:0] irq_src;
    logic [3:0] ier_out;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_irq_ctrl uut (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic ei, logic [2:0] es);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, ei});
        chk({req, " src"}, {5'd0, irq_src}, {5'd0, es});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ier_wr = 0; rx_push = 0; rx_pop = 0; overrun_pulse = 0;
        lsr_read = 0; msr_read = 0; iir_read = 0; tx_write = 0;
        msr_change = 0; rx_push_err = 0; rx_pop_err = 0;
    endtask

    task automatic set_ier(logic [3:0] v);
        ier_wr = 1; ier_wdata = v;
        step();
    endtask

    task automatic cleanup();
        lsr_read = 1; msr_read = 1; tx_write = 1;
        step();
    endtask

    task automatic t_reset();
        chk("R1 ier", {4'd0, ier_out}, 8'h00);
        chk_out("R1", 0, 3'b001);
    endtask

    task automatic t_rx_fifo();
        set_ier(4'b0001);
        rx_count = 7; step(); chk_out("R2 below", 0, 3'b001);
        rx_count = 8; step(); chk_out("R2 at trigger", 1, 3'b100);
        rx_count = 7; step(); chk_out("R2 drop", 0, 3'b001);
        rx_count = 0;
    endtask

    task automatic t_rx_nofifo();
        fifo_en = 0; rx_hold_full = 1; step(); chk_out("R3 full", 1, 3'b100);
        rx_hold_full = 0; step(); chk_out("R3 empty", 0, 3'b001);
        fifo_en = 1; step();
    endtask

    task automatic t_tx();
        set_ier(4'b0010); chk_out("R4 idle", 0, 3'b001);
        tx_count = 3; step(); chk_out("R4 below trigger", 1, 3'b010);
        iir_read = 1; step(); chk_out("R6 iir read clears", 0, 3'b001);
        tx_count = 10; step();
        tx_count = 3; step(); chk_out("R4 rise again", 1, 3'b010);
        tx_write = 1; step(); chk_out("R6 write clears", 0, 3'b001);
        tx_count = 10; fifo_en = 0; step();
        tx_hold_empty = 1; step(); chk_out("R4 hold empty", 1, 3'b010);
        tx_hold_empty = 0; fifo_en = 1; cleanup();
    endtask

    task automatic t_tx_enable();
        set_ier(4'b0000);
        tx_count = 2; step();
        tx_write = 1; step(); chk_out("R5 disabled", 0, 3'b001);
        set_ier(4'b0010); chk_out("R5 enable while empty", 1, 3'b010);
        tx_count = 10; cleanup();
    endtask

    task automatic t_overrun();
        set_ier(4'b0100);
        overrun_pulse = 1; step(); chk_out("R7 overrun", 1, 3'b110);
        lsr_read = 1; step(); chk_out("R10 read clears", 0, 3'b001);
        overrun_pulse = 1; step();
        overrun_pulse = 1; lsr_read = 1; step();
        chk_out("R10 set wins over clear", 1, 3'b110);
        lsr_read = 1; step(); chk_out("R10 clear after", 0, 3'b001);
    endtask

    task automatic t_err_timing();
        err_immediate = 0;
        rx_push = 1; rx_push_err = 3'b001; step();
        chk_out("R8 arrival ignored", 0, 3'b001);
        rx_pop = 1; rx_pop_err = 3'b001; step();
        chk_out("R8 read raises", 1, 3'b110);
        cleanup();
        err_immediate = 1;
        rx_push = 1; rx_push_err = 3'b010; step();
        chk_out("R9 arrival raises", 1, 3'b110);
        cleanup();
        rx_pop = 1; rx_pop_err = 3'b100; step();
        chk_out("R9 read ignored", 0, 3'b001);
        err_immediate = 0;
    endtask

    task automatic t_modem();
        set_ier(4'b0000);
        msr_change = 4'b0010; step(); chk_out("R11 gated", 0, 3'b001);
        set_ier(4'b1000); chk_out("R11 enabled", 1, 3'b000);
        msr_read = 1; step(); chk_out("R11 read clears", 0, 3'b001);
    endtask

    task automatic t_priority();
        cleanup();
        ier_wr = 1; ier_wdata = 4'b1111;
        rx_count = 8; overrun_pulse = 1; msr_change = 4'b0001; tx_count = 3;
        step(); chk_out("R13 line status first", 1, 3'b110);
        lsr_read = 1; step(); chk_out("R13 receive next", 1, 3'b100);
        rx_count = 0; step(); chk_out("R13 transmit next", 1, 3'b010);
        iir_read = 1; step(); chk_out("R13 modem last", 1, 3'b000);
        msr_read = 1; step(); chk_out("R13 none", 0, 3'b001);
        tx_count = 10; step();
    endtask

    task automatic t_polled();
        set_ier(4'b0000);
        rx_count = 8; overrun_pulse = 1; msr_change = 4'b1000; tx_count = 3;
        step(); chk_out("R12 all disabled", 0, 3'b001);
        step(); chk_out("R12 still quiet", 0, 3'b001);
        rx_count = 0; tx_count = 10; cleanup();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rx_fifo();
        t_rx_nofifo();
        t_tx();
        t_tx_enable();
        t_overrun();
        t_err_timing();
        t_modem();
        t_priority();
        t_polled();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule